// File: doc/BRIEF.md
# Return-to-zero / transition-signalling 1-of-4 bridge

This block sits where a die meets its neighbour. Inside the die, data moves as return-to-zero 1-of-4 tokens with a four-phase request/acknowledge cycle. Across the boundary, the same tokens move as rail transitions with a two-phase acknowledge. The bridge carries one channel in each direction. The outbound path turns return-to-zero tokens into rail toggles. The inbound path turns rail toggles back into return-to-zero tokens. Both sides have the same number of digits. Each digit is four rails, and a digit with value v drives rail v of its group. Digit d occupies bits 4d+3 down to 4d.

No clock travels with the data. Each path finds a complete token by checking the rails themselves. For verification, the model samples its inputs on a local clock. A digit with more than one active rail is a protocol error. It is reported and never forwarded.

Top module: `qdi_edge_bridge`

## Requirements
- R1: After reset, the outbound acknowledge, the outbound rails, the inbound acknowledge, the inbound token and both error flags are all low.
- R2: When every outbound digit has exactly one high rail (rail index equals digit value), each matching boundary rail toggles once and all other boundary rails keep their level. The outbound acknowledge then rises.
- R3: The outbound acknowledge stays high until the boundary acknowledge toggles, even if the sender has already returned to spacer.
- R4: After that toggle, the outbound acknowledge falls only once all outbound rails are low. Until then, no further rails toggle.
- R5: An outbound word in which some digit has no high rail is not forwarded and is not acknowledged.
- R6: An outbound digit with two or more high rails raises the outbound error flag. Nothing toggles and no acknowledge is given.
- R7: When every inbound digit differs from its stored phase in exactly one rail, the inbound token shows exactly those rails.
- R8: The inbound token holds until the local acknowledge rises and then returns to all-low. The boundary acknowledge toggles only after the local acknowledge has fallen.
- R9: An inbound digit with two or more changed rails raises the inbound error flag. The token stays all-low and the boundary acknowledge does not change.
- R10: An inbound word in which some digit has not yet changed is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| tx_rz_data | input | 4*DIGITS | Return-to-zero token from the die |
| tx_rz_ack | output | 1 | Four-phase acknowledge to the die |
| tx_tr_rails | output | 4*DIGITS | Transition-signalled rails across the boundary |
| tx_tr_ack | input | 1 | Two-phase acknowledge from across the boundary |
| tx_err | output | 1 | Outbound protocol error |
| rx_tr_rails | input | 4*DIGITS | Transition-signalled rails from across the boundary |
| rx_tr_ack | output | 1 | Two-phase acknowledge across the boundary |
| rx_rz_data | output | 4*DIGITS | Return-to-zero token into the die |
| rx_rz_ack | input | 1 | Four-phase acknowledge from the die |
| rx_err | output | 1 | Inbound protocol error |

## Verification
The properties assume that every sender follows its own handshake. A four-phase sender holds its token until it is acknowledged and then returns to spacer. A two-phase peer toggles its acknowledge only once per forwarded token and changes no rails until it sees the acknowledge toggle. The local consumer raises its acknowledge only for a presented token. The bench keeps to these rules by having each driver and responder wait for the opposite handshake edge. The only exception is deliberate: malformed and partial words are placed on an idle channel and then withdrawn or completed.

// File: rtl/qdi_edge_bridge.sv
module qdi_edge_bridge #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tx_rz_data,
  output logic         tx_rz_ack,
  output logic [W-1:0] tx_tr_rails,
  input  logic         tx_tr_ack,
  output logic         tx_err,
  input  logic [W-1:0] rx_tr_rails,
  output logic         rx_tr_ack,
  output logic [W-1:0] rx_rz_data,
  input  logic         rx_rz_ack,
  output logic         rx_err
);

  typedef enum logic [1:0] {TX_IDLE, TX_HOLD, TX_RTZ} tx_state_t;
  typedef enum logic [1:0] {RX_IDLE, RX_DRIVE, RX_RTZ} rx_state_t;

  function automatic logic word_complete(input logic [W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < DIGITS; d++)
      if ($countones(w[4*d +: 4]) != 1) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic word_multi(input logic [W-1:0] w);
    logic bad;
    bad = 1'b0;
    for (int d = 0; d < DIGITS; d++)
      if ($countones(w[4*d +: 4]) > 1) bad = 1'b1;
    return bad;
  endfunction

  tx_state_t    tx_st;
  logic         tx_ack_ref;
  rx_state_t    rx_st;
  logic [W-1:0] rx_phase;
  logic [W-1:0] rx_diff;

  assign rx_diff = rx_tr_rails ^ rx_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st       <= TX_IDLE;
      tx_rz_ack   <= 1'b0;
      tx_tr_rails <= '0;
      tx_ack_ref  <= 1'b0;
      tx_err      <= 1'b0;
    end else begin
      tx_err <= 1'b0;
      case (tx_st)
        TX_IDLE:
          if (word_multi(tx_rz_data)) begin
            tx_err <= 1'b1;
          end else if (word_complete(tx_rz_data)) begin
            tx_tr_rails <= tx_tr_rails ^ tx_rz_data;
            tx_rz_ack   <= 1'b1;
            tx_st       <= TX_HOLD;
          end
        TX_HOLD:
          if (tx_tr_ack != tx_ack_ref) begin
            tx_ack_ref <= tx_tr_ack;
            tx_st      <= TX_RTZ;
          end
        TX_RTZ:
          if (tx_rz_data == '0) begin
            tx_rz_ack <= 1'b0;
            tx_st     <= TX_IDLE;
          end
        default: tx_st <= TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st      <= RX_IDLE;
      rx_phase   <= '0;
      rx_rz_data <= '0;
      rx_tr_ack  <= 1'b0;
      rx_err     <= 1'b0;
    end else begin
      rx_err <= 1'b0;
      case (rx_st)
        RX_IDLE:
          if (word_multi(rx_diff)) begin
            rx_err <= 1'b1;
          end else if (word_complete(rx_diff)) begin
            rx_rz_data <= rx_diff;
            rx_phase   <= rx_tr_rails;
            rx_st      <= RX_DRIVE;
          end
        RX_DRIVE:
          if (rx_rz_ack) begin
            rx_rz_data <= '0;
            rx_st      <= RX_RTZ;
          end
        RX_RTZ:
          if (!rx_rz_ack) begin
            rx_tr_ack <= ~rx_tr_ack;
            rx_st     <= RX_IDLE;
          end
        default: rx_st <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/qdi_edge_bridge_chk.sv
module qdi_edge_bridge_chk #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] tx_rz_data,
  input logic         tx_rz_ack,
  input logic [W-1:0] tx_tr_rails,
  input logic         tx_tr_ack,
  input logic         tx_err,
  input logic [W-1:0] rx_tr_rails,
  input logic         rx_tr_ack,
  input logic [W-1:0] rx_rz_data,
  input logic         rx_rz_ack,
  input logic         rx_err
);

  function automatic logic one_each(input logic [W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < DIGITS; d++)
      if ($countones(w[4*d +: 4]) != 1) ok = 1'b0;
    return ok;
  endfunction

  logic prev_remote_ack;
  logic remote_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_remote_ack <= 1'b0;
      remote_seen     <= 1'b0;
    end else begin
      prev_remote_ack <= tx_tr_ack;
      if (tx_tr_ack != prev_remote_ack) remote_seen <= 1'b1;
      else if (!tx_rz_ack) remote_seen <= 1'b0;
    end
  end

  logic unused_ok;
  assign unused_ok = ^rx_tr_rails;

  AST_TX_ONE_RAIL_PER_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tr_rails != $past(tx_tr_rails)) |-> one_each(tx_tr_rails ^ $past(tx_tr_rails))); // R2
  AST_TX_TOGGLE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tr_rails != $past(tx_tr_rails)) |-> $rose(tx_rz_ack)); // R2
  AST_TX_ACK_WAITS_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_rz_ack) |-> remote_seen); // R3
  AST_TX_FALL_ON_SPACER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_rz_ack) |-> ($past(tx_rz_data) == '0)); // R4
  AST_TX_ERR_NO_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> (!tx_rz_ack && $stable(tx_tr_rails))); // R6
  AST_RX_TOKEN_WELL_FORMED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rz_data != '0) |-> one_each(rx_rz_data)); // R7
  AST_RX_TOKEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rz_data != '0 && !rx_rz_ack) |=> $stable(rx_rz_data)); // R8
  AST_RX_ACK_AFTER_RTZ: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tr_ack != $past(rx_tr_ack)) |-> (!$past(rx_rz_ack) && rx_rz_data == '0)); // R8
  AST_RX_ERR_NO_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> (rx_rz_data == '0 && $stable(rx_tr_ack))); // R9

endmodule

bind qdi_edge_bridge qdi_edge_bridge_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_rz_data(tx_rz_data), .tx_rz_ack(tx_rz_ack), .tx_tr_rails(tx_tr_rails),
  .tx_tr_ack(tx_tr_ack), .tx_err(tx_err),
  .rx_tr_rails(rx_tr_rails), .rx_tr_ack(rx_tr_ack), .rx_rz_data(rx_rz_data),
  .rx_rz_ack(rx_rz_ack), .rx_err(rx_err)
);

// File: tb/qdi_edge_bridge_test.sv
module qdi_edge_bridge_test;
  localparam int D = 4;
  localparam int W = 4 * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] tx_rz_data = '0;
  logic         tx_rz_ack;
  logic [W-1:0] tx_tr_rails;
  logic         tx_tr_ack = 1'b0;
  logic         tx_err;
  logic [W-1:0] rx_tr_rails = '0;
  logic         rx_tr_ack;
  logic [W-1:0] rx_rz_data;
  logic         rx_rz_ack = 1'b0;
  logic         rx_err;

  qdi_edge_bridge #(.DIGITS(D)) uut (.*);

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_tx[$];
  logic [W-1:0] exp_rx[$];
  bit remote_hold = 1'b0;
  bit done = 1'b0;

  function automatic logic [W-1:0] enc(input logic [2*D-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int d = 0; d < D; d++) r[4*d + v[2*d +: 2]] = 1'b1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // outbound monitor and remote responder
  initial begin
    logic [W-1:0] prev, delta, e;
    prev = '0;
    forever begin
      @(negedge clk);
      if (rst_n && tx_tr_rails !== prev) begin
        delta = tx_tr_rails ^ prev;
        prev = tx_tr_rails;
        e = (exp_tx.size() > 0) ? exp_tx.pop_front() : '0;
        chk(delta == e, "R2 toggled rails", delta, e);
        while (remote_hold) @(negedge clk);
        repeat (2) @(negedge clk);
        tx_tr_ack = ~tx_tr_ack;
      end
    end
  end

  // inbound consumer
  initial begin
    logic [W-1:0] e;
    logic a0;
    forever begin
      @(negedge clk);
      if (rst_n && rx_rz_data != '0) begin
        e = (exp_rx.size() > 0) ? exp_rx.pop_front() : '0;
        chk(rx_rz_data == e, "R7 inbound token", rx_rz_data, e);
        a0 = rx_tr_ack;
        repeat (3) @(negedge clk);
        chk(rx_rz_data == e, "R8 token held before ack", rx_rz_data, e);
        rx_rz_ack = 1'b1;
        while (rx_rz_data != '0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(rx_tr_ack == a0, "R8 no boundary ack while local ack high", W'(rx_tr_ack), W'(a0));
        rx_rz_ack = 1'b0;
      end
    end
  end

  task automatic send_tx(input logic [2*D-1:0] v);
    while (tx_rz_ack) @(negedge clk);
    exp_tx.push_back(enc(v));
    tx_rz_data = enc(v);
    while (!tx_rz_ack) @(negedge clk);
    @(negedge clk);
    tx_rz_data = '0;
    while (tx_rz_ack) @(negedge clk);
  endtask

  task automatic send_rx(input logic [2*D-1:0] v);
    logic a0;
    a0 = rx_tr_ack;
    exp_rx.push_back(enc(v));
    rx_tr_rails = rx_tr_rails ^ enc(v);
    while (rx_tr_ack == a0) @(negedge clk);
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [W-1:0] snap;
    logic a0;
    repeat (3) @(negedge clk);
    chk(tx_rz_ack == 0 && tx_tr_rails == 0 && rx_tr_ack == 0 && rx_rz_data == 0
        && tx_err == 0 && rx_err == 0, "R1 reset state",
        {tx_rz_ack, rx_tr_ack, tx_err, rx_err, tx_tr_rails[11:0]}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    send_tx(8'h00);
    send_tx(8'hFF);
    send_tx(8'h1B);
    send_tx(8'hE4);

    // R3 / R4: early spacer, remote ack withheld
    remote_hold = 1'b1;
    exp_tx.push_back(enc(8'h39));
    tx_rz_data = enc(8'h39);
    while (!tx_rz_ack) @(negedge clk);
    tx_rz_data = '0;
    repeat (6) @(negedge clk);
    chk(tx_rz_ack == 1'b1, "R3 ack held awaiting remote", W'(tx_rz_ack), W'(1));
    tx_rz_data = enc(8'h39);
    a0 = tx_tr_ack;
    remote_hold = 1'b0;
    while (tx_tr_ack == a0) @(negedge clk);
    snap = tx_tr_rails;
    repeat (4) @(negedge clk);
    chk(tx_rz_ack == 1'b1 && tx_tr_rails == snap, "R4 ack stays until spacer", tx_tr_rails, snap);
    tx_rz_data = '0;
    repeat (3) @(negedge clk);
    chk(tx_rz_ack == 1'b0, "R4 ack falls after spacer", W'(tx_rz_ack), W'(0));

    // R5: partial outbound word
    snap = tx_tr_rails;
    tx_rz_data = enc(8'hA6) & ~W'(16'h000F);
    repeat (5) @(negedge clk);
    chk(tx_rz_ack == 0 && tx_tr_rails == snap, "R5 partial not forwarded", tx_tr_rails, snap);
    exp_tx.push_back(enc(8'hA6));
    tx_rz_data = enc(8'hA6);
    while (!tx_rz_ack) @(negedge clk);
    @(negedge clk);
    tx_rz_data = '0;
    while (tx_rz_ack) @(negedge clk);

    // R6: multi-hot outbound digit
    snap = tx_tr_rails;
    tx_rz_data = enc(8'h55) | W'(16'h0001) | W'(16'h0002);
    repeat (4) @(negedge clk);
    chk(tx_err == 1 && tx_rz_ack == 0 && tx_tr_rails == snap, "R6 error not forwarded",
        tx_tr_rails, snap);
    tx_rz_data = '0;
    repeat (2) @(negedge clk);
    chk(tx_err == 0, "R6 error clears on spacer", W'(tx_err), W'(0));
    send_tx(8'h72);

    // inbound tokens
    send_rx(8'h00);
    send_rx(8'hFF);
    send_rx(8'h1B);
    send_rx(8'h1B);

    // R10: partial inbound transition
    rx_tr_rails = rx_tr_rails ^ (enc(8'hC9) & W'(16'h000F));
    repeat (5) @(negedge clk);
    chk(rx_rz_data == '0, "R10 partial not forwarded", rx_rz_data, '0);
    a0 = rx_tr_ack;
    exp_rx.push_back(enc(8'hC9));
    rx_tr_rails = rx_tr_rails ^ (enc(8'hC9) & ~W'(16'h000F));
    while (rx_tr_ack == a0) @(negedge clk);

    // R9: multi-hot inbound digit, then withdrawn
    a0 = rx_tr_ack;
    rx_tr_rails = rx_tr_rails ^ enc(8'h94) ^ W'(16'h0002);
    repeat (5) @(negedge clk);
    chk(rx_err == 1 && rx_rz_data == '0 && rx_tr_ack == a0, "R9 error not forwarded",
        rx_rz_data, '0);
    exp_rx.push_back(enc(8'h94));
    rx_tr_rails = rx_tr_rails ^ W'(16'h0002);
    while (rx_tr_ack == a0) @(negedge clk);
    chk(rx_err == 0, "R9 error cleared after repair", W'(rx_err), W'(0));

    repeat (10) @(negedge clk);
    chk(exp_tx.size() == 0 && exp_rx.size() == 0, "R2 R7 queues drained",
        W'(exp_tx.size() + exp_rx.size()), '0);
    done = 1'b1;
    summary();
  end
endmodule